// File: doc/BRIEF.md
# Wake Event Combiner and Pulse Stretcher

This block sits at the end of a MAC receive path. The address and frame-type matchers report per-frame wake hits on four strobes: magic packet, ARP request, station address match and multicast hash match. The receive path also marks each frame's end and says whether that frame was errored. The block holds the hits seen during a frame. At the end of the frame it applies the enables and the configuration gates. When at least one source qualifies, it raises a single wake output for a fixed number of receive clock cycles.

Every pin is a plain control or status level or strobe. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure. The upstream matchers may pulse a hit strobe in any cycle of a frame, including the end-of-frame cycle. The block accepts every strobe that arrives while receive is enabled.

Top module: `wake_combiner`

## Requirements
- R1: A qualifying frame end, sampled on a rising clock edge, drives `wake` high from that edge for exactly PULSE_LEN receive clock cycles (64 by default). `wake` then returns low.
- R2: Each source has its own enable in `ev_en`: bit 0 magic packet, bit 1 ARP request, bit 2 station address match, bit 3 multicast hash match. A hit from a disabled source never produces a wake.
- R3: A magic packet hit counts only when `frame_err` is low in the end-of-frame cycle.
- R4: ARP, station address and multicast hits produce a wake even when `frame_err` is high at frame end.
- R5: An ARP hit counts only when `bcast_ok` is high.
- R6: A multicast hit counts only when `mhash_on` is high and no `dst_bcast` strobe was seen in the same frame.
- R7: While `rx_en` is low, hit strobes are ignored and a frame end raises no wake. A receive buffer is not required.
- R8: A qualifying frame end while `wake` is already high restarts the pulse. `wake` then stays high for a full PULSE_LEN cycles counted from that frame end.
- R9: Hits accumulate across the frame and are judged only at `eof`. A frame with no hits of its own never inherits hits from an earlier frame.
- R10: A synchronous active-high `rst` clears the held hits, the cycle counter and `wake`. Reset takes effect on the next clock edge, even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | MAC receive enable |
| bcast_ok | input | 1 | Broadcast frames accepted (gates ARP) |
| mhash_on | input | 1 | Multicast hash filtering enabled (gates multicast) |
| ev_en | input | 4 | Per-source wake enables (bit 0 magic, 1 ARP, 2 address, 3 multicast) |
| hit_magic | input | 1 | Magic packet detected in the current frame |
| hit_arp | input | 1 | ARP request to this station detected |
| hit_addr | input | 1 | Destination matched the station address |
| hit_mcast | input | 1 | Destination matched the multicast hash |
| dst_bcast | input | 1 | Destination is the broadcast address |
| eof | input | 1 | End-of-frame strobe |
| frame_err | input | 1 | Frame errored, valid with `eof` |
| wake | output | 1 | Wake pulse |

## Verification
The bench builds the block with the default PULSE_LEN of 64. At that value a single directed run can count every pulse from its first high cycle to its last, and can restart one pulse halfway through. Because 64 is a power of two, the counter uses its full width, so an off-by-one in the load value or in the end test changes the measured length. Each source is exercised with its own gate both open and closed, and with clean and errored frames.

// File: rtl/wake_pkg.sv
package wake_pkg;

  localparam int unsigned NUM_EV = 4;

  typedef enum int unsigned {
    EV_MAGIC = 0,
    EV_ARP   = 1,
    EV_ADDR  = 2,
    EV_MCAST = 3
  } wake_ev_e;

  typedef logic [NUM_EV-1:0] ev_vec_t;

endpackage

// File: rtl/wake_evt_latch.sv
// Holds per-source hits from the start of a frame until its end strobe.
module wake_evt_latch #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rx_en,
  input  logic [N-1:0] hit,
  input  logic         dst_bc,
  input  logic         eof,
  output logic [N-1:0] seen,
  output logic         bc_seen
);

  logic [N-1:0] held;
  logic         bc_held;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)         held[i] <= 1'b0;
      else if (eof)    held[i] <= 1'b0;
      else if (rx_en)  held[i] <= held[i] | hit[i];
    end
    // a strobe in the end-of-frame cycle still belongs to that frame
    assign seen[i] = held[i] | (rx_en & hit[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)         bc_held <= 1'b0;
    else if (eof)    bc_held <= 1'b0;
    else if (rx_en)  bc_held <= bc_held | dst_bc;
  end
  assign bc_seen = bc_held | (rx_en & dst_bc);

endmodule

// File: rtl/wake_qualify.sv
// Applies enables, configuration gates and error rules at frame end.
module wake_qualify
  import wake_pkg::*;
(
  input  ev_vec_t seen,
  input  logic    bc_seen,
  input  ev_vec_t ev_en,
  input  logic    frame_err,
  input  logic    bcast_ok,
  input  logic    mhash_on,
  input  logic    rx_en,
  input  logic    eof,
  output logic    fire
);

  ev_vec_t gate;
  ev_vec_t qual;

  always_comb begin
    gate           = '1;
    gate[EV_MAGIC] = ~frame_err;          // only clean frames carry magic
    gate[EV_ARP]   = bcast_ok;
    gate[EV_ADDR]  = 1'b1;
    gate[EV_MCAST] = mhash_on & ~bc_seen;
    qual           = seen & ev_en & gate;
  end

  assign fire = eof & rx_en & (|qual);

endmodule

// File: rtl/wake_pulse_gen.sv
// Stretches a one-cycle fire into a PULSE_LEN-cycle level; refire restarts.
module wake_pulse_gen #(
  parameter int unsigned PULSE_LEN = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic wake
);

  localparam int unsigned CW = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN - 1);

  logic [CW-1:0] remain;
  logic          wake_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      wake_q <= 1'b0;
    end else if (fire) begin
      remain <= LOAD;
      wake_q <= 1'b1;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end else begin
      wake_q <= 1'b0;
    end
  end

  assign wake = wake_q;

endmodule

// File: rtl/wake_combiner.sv
module wake_combiner
  import wake_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en,
  input  logic       bcast_ok,
  input  logic       mhash_on,
  input  logic [3:0] ev_en,
  input  logic       hit_magic,
  input  logic       hit_arp,
  input  logic       hit_addr,
  input  logic       hit_mcast,
  input  logic       dst_bcast,
  input  logic       eof,
  input  logic       frame_err,
  output logic       wake
);

  ev_vec_t hits;
  ev_vec_t seen;
  logic    bc_seen;
  logic    fire;

  always_comb begin
    hits           = '0;
    hits[EV_MAGIC] = hit_magic;
    hits[EV_ARP]   = hit_arp;
    hits[EV_ADDR]  = hit_addr;
    hits[EV_MCAST] = hit_mcast;
  end

  wake_evt_latch #(.N(NUM_EV)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .rx_en   (rx_en),
    .hit     (hits),
    .dst_bc  (dst_bcast),
    .eof     (eof),
    .seen    (seen),
    .bc_seen (bc_seen)
  );

  wake_qualify u_qual (
    .seen      (seen),
    .bc_seen   (bc_seen),
    .ev_en     (ev_en),
    .frame_err (frame_err),
    .bcast_ok  (bcast_ok),
    .mhash_on  (mhash_on),
    .rx_en     (rx_en),
    .eof       (eof),
    .fire      (fire)
  );

  wake_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk  (clk),
    .rst  (rst),
    .fire (fire),
    .wake (wake)
  );

endmodule

// File: rtl/wake_combiner_chk.sv
module wake_combiner_chk #(
  parameter int unsigned PULSE_LEN = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       rx_en,
  input logic [3:0] ev_en,
  input logic       eof,
  input logic       frame_err,
  input logic       wake
);

  localparam int unsigned RW = $clog2(PULSE_LEN + 2) + 1;
  logic [RW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst)                           hi_run <= '0;
    else if (!wake)                    hi_run <= '0;
    else if (hi_run <= RW'(PULSE_LEN)) hi_run <= hi_run + 1'b1;
  end

  AST_RISE_AT_EOF: assert property (@(posedge clk) disable iff (rst)
    $rose(wake) |-> $past(eof)) else $error("wake rose without frame end"); // R9

  AST_RISE_NEEDS_RX: assert property (@(posedge clk) disable iff (rst)
    $rose(wake) |-> $past(rx_en)) else $error("wake rose with receive off"); // R7

  AST_ERR_NO_MAGIC: assert property (@(posedge clk) disable iff (rst)
    ($rose(wake) && $past(frame_err)) |-> ($past(ev_en[3:1]) != 3'b000))
    else $error("errored frame woke on magic alone"); // R3

  AST_FULL_LENGTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(wake) && !$past(rst)) |-> (hi_run >= RW'(PULSE_LEN)))
    else $error("wake pulse cut short"); // R1

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> !wake) else $error("wake high after reset"); // R10

endmodule

bind wake_combiner wake_combiner_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_en     (rx_en),
  .ev_en     (ev_en),
  .eof       (eof),
  .frame_err (frame_err),
  .wake      (wake)
);

// File: tb/sim_wake_combiner.sv
module sim_wake_combiner;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned PLEN       = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0, bcast_ok = 1'b0, mhash_on = 1'b0;
  logic [3:0] ev_en = 4'h0;
  logic       hit_magic = 1'b0, hit_arp = 1'b0, hit_addr = 1'b0, hit_mcast = 1'b0;
  logic       dst_bcast = 1'b0, eof = 1'b0, frame_err = 1'b0;
  logic       wake;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_combiner #(.PULSE_LEN(PLEN)) u0 (
    .clk, .rst, .rx_en, .bcast_ok, .mhash_on, .ev_en,
    .hit_magic, .hit_arp, .hit_addr, .hit_mcast,
    .dst_bcast, .eof, .frame_err, .wake
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // hits {mcast,addr,arp,magic} in one cycle, then end of frame
  task automatic frame(input logic [3:0] h, input logic bc, input logic err);
    @(negedge clk);
    {hit_mcast, hit_addr, hit_arp, hit_magic} = h;
    dst_bcast = bc;
    @(negedge clk);
    {hit_mcast, hit_addr, hit_arp, hit_magic} = 4'h0;
    dst_bcast = 1'b0;
    eof = 1'b1;
    frame_err = err;
    @(negedge clk);
    eof = 1'b0;
    frame_err = 1'b0;
  endtask

  task automatic expect_pulse(input string req);
    int n = 0;
    check(wake == 1'b1, req, int'(wake), 1);
    while (wake && n < 4 * PLEN) begin
      n++;
      @(negedge clk);
    end
    check(n == PLEN, req, n, PLEN);
  endtask

  task automatic expect_quiet(input string req);
    int hi = 0;
    for (int i = 0; i < 6; i++) begin
      if (wake) hi++;
      @(negedge clk);
    end
    check(hi == 0, req, hi, 0);
  endtask

  task automatic settle();
    while (wake) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check(wake == 1'b0, "R10 reset state", int'(wake), 0);
  endtask

  task automatic t_magic();
    ev_en = 4'b0001;
    frame(4'b0001, 1'b0, 1'b0);
    expect_pulse("R1 R3 magic clean");
    frame(4'b0001, 1'b0, 1'b1);
    expect_quiet("R3 magic errored");
    settle();
  endtask

  task automatic t_errored_ok();
    ev_en = 4'b1110; bcast_ok = 1'b1; mhash_on = 1'b1;
    frame(4'b0010, 1'b1, 1'b1);
    expect_pulse("R4 arp errored");
    frame(4'b0100, 1'b0, 1'b1);
    expect_pulse("R4 addr errored");
    frame(4'b1000, 1'b0, 1'b1);
    expect_pulse("R4 mcast errored");
    settle();
  endtask

  task automatic t_gates();
    ev_en = 4'b1111; bcast_ok = 1'b0; mhash_on = 1'b1;
    frame(4'b0010, 1'b1, 1'b0);
    expect_quiet("R5 arp without broadcast");
    frame(4'b1000, 1'b1, 1'b0);
    expect_quiet("R6 mcast with broadcast dest");
    mhash_on = 1'b0;
    frame(4'b1000, 1'b0, 1'b0);
    expect_quiet("R6 mcast hash off");
    mhash_on = 1'b1; bcast_ok = 1'b1;
    settle();
  endtask

  task automatic t_enables();
    for (int s = 0; s < 4; s++) begin
      ev_en = ~(4'b0001 << s);
      frame(4'b0001 << s, 1'b0, 1'b0);
      expect_quiet($sformatf("R2 source %0d disabled", s));
    end
    ev_en = 4'b1111;
    settle();
  endtask

  task automatic t_rx_off();
    ev_en = 4'b1111;
    rx_en = 1'b0;
    frame(4'b0100, 1'b0, 1'b0);
    expect_quiet("R7 receive off at eof");
    // hit while off, eof after turning on: the hit must be forgotten
    @(negedge clk); hit_addr = 1'b1;
    @(negedge clk); hit_addr = 1'b0; rx_en = 1'b1;
    frame(4'b0000, 1'b0, 1'b0);
    expect_quiet("R7 hit while receive off");
    settle();
  endtask

  task automatic t_restart();
    int n = 0;
    frame(4'b0100, 1'b0, 1'b0);
    repeat (30) @(negedge clk);
    frame(4'b0100, 1'b0, 1'b0);
    while (wake && n < 4 * PLEN) begin
      n++;
      @(negedge clk);
    end
    check(n == PLEN, "R8 restart length", n, PLEN);
    settle();
  endtask

  task automatic t_accumulate();
    @(negedge clk); hit_addr = 1'b1;
    @(negedge clk); hit_addr = 1'b0;
    repeat (8) @(negedge clk);
    check(wake == 1'b0, "R9 no wake before eof", int'(wake), 0);
    frame(4'b0000, 1'b0, 1'b0);
    expect_pulse("R9 held hit judged at eof");
    frame(4'b0000, 1'b0, 1'b0);
    expect_quiet("R9 empty frame after hit");
    settle();
  endtask

  task automatic t_reset_mid();
    frame(4'b0100, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(wake == 1'b0, "R10 reset mid pulse", int'(wake), 0);
    rst = 1'b0;
    expect_quiet("R10 stays low after reset");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rx_en = 1'b1;
    @(negedge clk);
    t_reset();
    t_magic();
    t_errored_ok();
    t_gates();
    t_enables();
    t_rx_off();
    t_restart();
    t_accumulate();
    t_reset_mid();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule